// File: doc/BRIEF.md
# Dual-Issue In-Order Integer Dispatch

This block closes the decode stage of a two-way superscalar integer core. Every clock it looks at a pair of decoded instructions, slot 0 being the older and slot 1 the younger in program order. When the two do not interfere, both go out together: the older to execution lane 0 and the younger to lane 1. When they interfere, the block sends the older one to lane 0 and raises a stall toward decode. On the next cycle it sends the younger one to lane 0 as well, and lane 1 sits idle for both cycles.

The block contains both integer ALUs and a register file of eight 16-bit registers with two write ports, which both lanes share. An issued instruction reads its operands during its execute cycle and writes its result at the end of that cycle. Each instruction is 16 bits: opcode in [15:12], destination in [11:9], first source in [8:6], second source in [5:3]. Bits [2:0] are ignored. A read-only inspection port exposes any register so that results can be observed.

Top module: `dual_dispatch`

## Requirements
- R1: After reset every register reads 0, stall is low and neither lane issues.
- R2: When both slots are valid, the younger reads neither source equal to the older's destination, and the two destinations differ, the older issues on lane 0 and the younger on lane 1 in the same cycle with stall low. A stream of such pairs issues two instructions every cycle.
- R3: When both slots are valid and either source field of the younger equals the older's destination (compared for every opcode), the older issues alone on lane 0 with stall high. In the next cycle the younger issues alone on lane 0 with stall low. Lane 1 stays idle in both cycles.
- R4: When both slots are valid and the destinations are equal, the pair is serialized exactly as in R3.
- R5: When only one slot is valid, that instruction issues on lane 0, lane 1 stays idle and stall stays low.
- R6: When neither slot is valid, nothing issues and the register contents do not change.
- R7: Opcodes: 0 add, 1 subtract (src1-src2), 2 AND, 3 OR, 4 XOR, 5 NOT src1, 6 shift left, 7 logical shift right, 8 rotate left, 9 rotate right. Shift and rotate amounts are src2[3:0]. Codes 10 to 15 copy src1.
- R8: The register file ends up exactly as if the instructions had run one at a time in program order. An instruction sees the results of all instructions issued in earlier cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot0_valid | input | 1 | Older instruction present |
| slot0_instr | input | 16 | Older instruction |
| slot1_valid | input | 1 | Younger instruction present |
| slot1_instr | input | 16 | Younger instruction |
| stall | output | 1 | Decode must hold the current pair for one more cycle |
| lane0_issue | output | 1 | An instruction issues on lane 0 this cycle |
| lane1_issue | output | 1 | An instruction issues on lane 1 this cycle |
| peek_addr | input | 3 | Register to inspect |
| peek_data | output | 16 | Contents of the inspected register |

## Verification
The hardest case to reach is the second cycle of a serialized pair. It exists only while decode holds the pair, and during it an input slot can be valid while the unit ignores that slot's routing. The random stimulus draws register fields from just eight names, so dependent and same-destination pairs turn up often. Those pairs also get mixed with half-valid and empty slots. The bench keeps the pair steady across the stall exactly as decode must. The register file is compared with a sequential model at regular intervals, which shows whether the result of a serialized older instruction was visible to its younger partner.

// File: rtl/dd_pkg.sv
package dd_pkg;
  localparam int XLEN   = 16;
  localparam int NREG   = 8;
  localparam int RAW_W  = $clog2(NREG);
  localparam int OPW    = 4;
  localparam int LANES  = 2;
  localparam int SHW    = $clog2(XLEN);

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_OR  = 4'd3,
    OP_XOR = 4'd4, OP_NOT = 4'd5, OP_SHL = 4'd6, OP_SHR = 4'd7,
    OP_ROL = 4'd8, OP_ROR = 4'd9
  } op_e;

  typedef struct packed {
    logic [OPW-1:0]   op;
    logic [RAW_W-1:0] rd;
    logic [RAW_W-1:0] rs1;
    logic [RAW_W-1:0] rs2;
    logic [2:0]       spare;
  } instr_t;
endpackage

// File: rtl/dd_pair_check.sv
module dd_pair_check
  import dd_pkg::*;
(
  input  instr_t older,
  input  instr_t younger,
  output logic   raw_hit,
  output logic   waw_hit
);
  always_comb begin
    raw_hit = (younger.rs1 == older.rd) || (younger.rs2 == older.rd);
    waw_hit = (younger.rd == older.rd);
  end
endmodule

// File: rtl/dd_issue_ctrl.sv
module dd_issue_ctrl
  import dd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                v0,
  input  instr_t              i0,
  input  logic                v1,
  input  instr_t              i1,
  input  logic                raw_hit,
  input  logic                waw_hit,
  output logic                stall,
  output logic [LANES-1:0]    iss_v,
  output logic [LANES-1:0]    ex_v,
  output instr_t              ex_i [LANES]
);
  logic   second_q, second_d;
  instr_t iss_i [LANES];
  logic   unsafe;

  assign unsafe = v0 && v1 && (raw_hit || waw_hit);

  always_comb begin
    second_d = 1'b0;
    stall    = 1'b0;
    iss_v    = '0;
    iss_i[0] = i0;
    iss_i[1] = i1;
    if (second_q) begin
      iss_v[0] = 1'b1;
      iss_i[0] = i1;
    end else if (unsafe) begin
      iss_v[0] = 1'b1;
      stall    = 1'b1;
      second_d = 1'b1;
    end else if (v0) begin
      iss_v[0] = 1'b1;
      iss_v[1] = v1;
    end else if (v1) begin
      iss_v[0] = 1'b1;
      iss_i[0] = i1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) second_q <= 1'b0;
    else        second_q <= second_d;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_ex
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ex_v[k] <= 1'b0;
      else        ex_v[k] <= iss_v[k];
    end
    always_ff @(posedge clk) begin
      if (iss_v[k]) ex_i[k] <= iss_i[k];
    end
  end

  assert_lane1_idle_in_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !iss_v[1]);
  assert_stall_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!stall && iss_v[0] && !iss_v[1]));
  assert_lone_slot_no_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (v0 ^ v1) |-> !stall);
  assert_idle_no_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!v0 && !v1 && !second_q) |-> (iss_v == '0));
endmodule

// File: rtl/dd_alu.sv
module dd_alu
  import dd_pkg::*;
(
  input  logic [OPW-1:0]  op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  logic [SHW-1:0] sh;
  assign sh = b[SHW-1:0];

  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOT:  y = ~a;
      OP_SHL:  y = a << sh;
      OP_SHR:  y = a >> sh;
      OP_ROL:  y = (a << sh) | (a >> (XLEN - {1'b0, sh}));
      OP_ROR:  y = (a >> sh) | (a << (XLEN - {1'b0, sh}));
      default: y = a;
    endcase
  end
endmodule

// File: rtl/dd_regfile.sv
module dd_regfile
  import dd_pkg::*;
#(
  parameter int NRD = 4,
  parameter int NWR = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NRD-1:0][RAW_W-1:0]   raddr,
  output logic [NRD-1:0][XLEN-1:0]    rdata,
  input  logic [NWR-1:0]              wen,
  input  logic [NWR-1:0][RAW_W-1:0]   waddr,
  input  logic [NWR-1:0][XLEN-1:0]    wdata,
  input  logic [RAW_W-1:0]            paddr,
  output logic [XLEN-1:0]             pdata
);
  logic [NREG-1:0][XLEN-1:0] mem_q, mem_d;

  always_comb begin
    mem_d = mem_q;
    for (int w = 0; w < NWR; w++) begin
      if (wen[w]) mem_d[waddr[w]] = wdata[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else        mem_q <= mem_d;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata[r] = mem_q[raddr[r]];
  end
  assign pdata = mem_q[paddr];

  assert_younger_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wen[0] && wen[1] && waddr[0] == waddr[1]) |=> (mem_q[$past(waddr[1])] == $past(wdata[1])));
  assert_lane0_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wen[0] && !(wen[1] && waddr[1] == waddr[0])) |=> (mem_q[$past(waddr[0])] == $past(wdata[0])));
endmodule

// File: rtl/dual_dispatch.sv
module dual_dispatch
  import dd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot0_valid,
  input  logic [15:0]       slot0_instr,
  input  logic              slot1_valid,
  input  logic [15:0]       slot1_instr,
  output logic              stall,
  output logic              lane0_issue,
  output logic              lane1_issue,
  input  logic [2:0]        peek_addr,
  output logic [15:0]       peek_data
);
  instr_t                     i0, i1;
  logic                       raw_hit, waw_hit;
  logic [LANES-1:0]           iss_v, ex_v;
  instr_t                     ex_i [LANES];
  logic [2*LANES-1:0][RAW_W-1:0] raddr;
  logic [2*LANES-1:0][XLEN-1:0]  rdata;
  logic [LANES-1:0][RAW_W-1:0]   waddr;
  logic [LANES-1:0][XLEN-1:0]    wdata;

  assign i0 = instr_t'(slot0_instr);
  assign i1 = instr_t'(slot1_instr);

  dd_pair_check u_chk (
    .older(i0), .younger(i1), .raw_hit(raw_hit), .waw_hit(waw_hit)
  );

  dd_issue_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .v0(slot0_valid), .i0(i0), .v1(slot1_valid), .i1(i1),
    .raw_hit(raw_hit), .waw_hit(waw_hit),
    .stall(stall), .iss_v(iss_v), .ex_v(ex_v), .ex_i(ex_i)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign raddr[2*k]   = ex_i[k].rs1;
    assign raddr[2*k+1] = ex_i[k].rs2;
    assign waddr[k]     = ex_i[k].rd;
    dd_alu u_alu (
      .op(ex_i[k].op), .a(rdata[2*k]), .b(rdata[2*k+1]), .y(wdata[k])
    );
  end

  dd_regfile #(.NRD(2*LANES), .NWR(LANES)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .raddr(raddr), .rdata(rdata),
    .wen(ex_v), .waddr(waddr), .wdata(wdata),
    .paddr(peek_addr), .pdata(peek_data)
  );

  assign lane0_issue = iss_v[0];
  assign lane1_issue = iss_v[1];

  assert_paired_is_safe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lane1_issue |-> (i1.rs1 != i0.rd && i1.rs2 != i0.rd && i1.rd != i0.rd));
  assert_conflict_serializes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot0_valid && slot1_valid && i0.rd == i1.rd) |-> !lane1_issue);
endmodule

// File: tb/sim_dual_dispatch.sv
module sim_dual_dispatch;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        s0v, s1v;
  logic [15:0] s0i, s1i;
  logic        stall, l0, l1;
  logic [2:0]  paddr;
  logic [15:0] pdata;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dispatch u0 (
    .clk(clk), .rst_n(rst_n),
    .slot0_valid(s0v), .slot0_instr(s0i),
    .slot1_valid(s1v), .slot1_instr(s1i),
    .stall(stall), .lane0_issue(l0), .lane1_issue(l1),
    .peek_addr(paddr), .peek_data(pdata)
  );

  function automatic logic [15:0] mk(input int op, input int rd, input int a, input int b);
    mk = {op[3:0], rd[2:0], a[2:0], b[2:0], 3'b000};
  endfunction

  function automatic logic [15:0] ref_alu(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
    logic [31:0] dbl;
    int s;
    s = int'(b[3:0]);
    dbl = {a, a};
    case (op)
      4'd0: ref_alu = a + b;
      4'd1: ref_alu = a - b;
      4'd2: ref_alu = a & b;
      4'd3: ref_alu = a | b;
      4'd4: ref_alu = a ^ b;
      4'd5: ref_alu = ~a;
      4'd6: ref_alu = a << s;
      4'd7: ref_alu = a >> s;
      4'd8: ref_alu = dbl[31-s -: 16];
      4'd9: ref_alu = dbl[s +: 16];
      default: ref_alu = a;
    endcase
  endfunction

  task automatic model_exec(input logic [15:0] ins);
    model[ins[11:9]] = ref_alu(ins[15:12], model[ins[8:6]], model[ins[5:3]]);
  endtask

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_lanes(input string tag, input logic es, input logic e0, input logic e1);
    chk(stall == es && l0 == e0 && l1 == e1, tag, {13'd0, stall, l0, l1}, {13'd0, es, e0, e1});
  endtask

  // Present a pair, check routing, update model in program order.
  task automatic send(input logic v0, input logic [15:0] i0, input logic v1, input logic [15:0] i1, input string tag);
    logic hz;
    @(negedge clk);
    s0v = v0; s0i = i0; s1v = v1; s1i = i1;
    hz = v0 && v1 && (i1[8:6] == i0[11:9] || i1[5:3] == i0[11:9] || i1[11:9] == i0[11:9]);
    #1;
    if (hz) begin
      chk_lanes({tag, " serial first (R3/R4)"}, 1'b1, 1'b1, 1'b0);
      @(negedge clk);
      #1;
      chk_lanes({tag, " serial second (R3/R4)"}, 1'b0, 1'b1, 1'b0);
    end else if (v0 && v1) begin
      chk_lanes({tag, " dual (R2)"}, 1'b0, 1'b1, 1'b1);
    end else if (v0 || v1) begin
      chk_lanes({tag, " single (R5)"}, 1'b0, 1'b1, 1'b0);
    end else begin
      chk_lanes({tag, " empty (R6)"}, 1'b0, 1'b0, 1'b0);
    end
    if (v0) model_exec(i0);
    if (v1) model_exec(i1);
  endtask

  task automatic check_regs(input string tag);
    @(negedge clk);
    s0v = 1'b0; s1v = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int r = 0; r < 8; r++) begin
      paddr = r[2:0];
      #1;
      chk(pdata == model[r], tag, pdata, model[r]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    for (int r = 0; r < 8; r++) model[r] = '0;
    rst_n = 1'b0; s0v = 0; s1v = 0; s0i = '0; s1i = '0; paddr = '0;
    seed = $urandom(32'd1234);
    #(CLK_PERIOD * 3);
    #1;
    chk_lanes("R1 reset outputs", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    check_regs("R1 reset regs");

    // R7 seed values and operations
    send(1, mk(5, 1, 0, 0), 1, mk(5, 2, 3, 3), "R7 not");      // r1=r2=ffff
    send(1, mk(0, 3, 1, 2), 0, '0, "R7 add");                   // r3=fffe
    send(1, mk(7, 4, 1, 3), 1, mk(6, 5, 2, 1), "R7 shifts");
    send(1, mk(8, 6, 3, 4), 1, mk(9, 7, 3, 1), "R7 rotates");
    send(1, mk(1, 0, 3, 4), 1, mk(4, 1, 6, 7), "R7 sub/xor");
    send(1, mk(2, 2, 6, 7), 1, mk(3, 4, 3, 0), "R7 and/or");
    send(1, mk(12, 5, 6, 0), 0, '0, "R7 copy");
    check_regs("R7 results");

    // R3 RAW via rs1, rs2; R4 WAW; R8 visibility
    send(1, mk(0, 1, 3, 3), 1, mk(0, 2, 1, 5), "R3 raw rs1");
    send(1, mk(4, 6, 2, 3), 1, mk(1, 7, 0, 6), "R3 raw rs2");
    send(1, mk(0, 5, 1, 2), 1, mk(3, 5, 6, 7), "R4 waw");
    check_regs("R8 serialized results");

    // R5 lone slots, R6 empty
    send(0, mk(0, 0, 1, 2), 1, mk(5, 0, 0, 0), "R5 younger only");
    send(0, mk(5, 1, 1, 1), 0, mk(5, 2, 2, 2), "R6 none valid");
    check_regs("R6 regs unchanged");

    // R2 back-to-back independent pairs, two per cycle
    for (int n = 0; n < 6; n++)
      send(1, mk(n % 10, 0, 4, 5), 1, mk((n + 3) % 10, 1, 6, 7), "R2 stream");
    check_regs("R2/R8 stream regs");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a, b;
      logic va, vb;
      a = $urandom; b = $urandom;
      va = ($urandom % 8) != 0;
      vb = ($urandom % 8) != 0;
      send(va, a, vb, b, "rand");
      if (n % 40 == 39) check_regs("R8 random regs");
    end
    check_regs("R8 final regs");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule